// File: doc/BRIEF.md
# Variable-Length Instruction Parcel Assembler

This block sits between an instruction fetch path and a decoder. It receives 16-bit parcels one at a time, in rising halfword address order, over a valid/ready handshake. It joins them into whole instructions and presents each one with its length in bits, the address of its first parcel, and flags for illegal, reserved and misaligned cases. The number of parcels in an instruction is not fixed. It is read from a prefix code in the low bits of the first parcel, so one instruction may need a single parcel and the next may need eleven.

A parameter sets the longest instruction the block accepts, from 32 up to 176 bits. A second parameter turns 16-bit instruction support on or off, and this also changes the alignment rule. A synchronous flush throws away a partly built instruction and loads a new fetch address. The address counter is as wide as the address parameter and wraps through zero.

Top module: `parcel_asm`

## Requirements
- R1: When the first parcel's two lowest bits are anything other than 11 and 16-bit support is on, the instruction is 16 bits long. Within an assembled instruction, the parcel that arrived first forms the least significant 16 bits, and every bit above the instruction length reads zero.
- R2: When the first parcel's bits [1:0] are 11 and bits [4:2] are not 111, the instruction is 32 bits long.
- R3: When the first parcel's low six bits are 011111, the instruction is 48 bits long. When its low seven bits are 0111111, it is 64 bits long.
- R4: When the first parcel's low seven bits are 1111111 and bits [14:12] hold a value n other than 7, the instruction is 80+16*n bits long.
- R5: When the first parcel's low seven bits are 1111111 and bits [14:12] are 111, the reserved flag is raised and the block collects parcels up to the maximum length. The illegal flag is raised as well when every bit of that maximum-length instruction is one.
- R6: A first parcel equal to 0x0000 raises the illegal flag. It counts as 16 bits long when 16-bit support is on.
- R7: When the decoded length is greater than the maximum length, the illegal flag is raised. The block uses only as many parcels as the maximum length holds and reports the maximum length. The next parcel then starts a new instruction.
- R8: The reported address is the address of the instruction's first parcel. The address rises by 2 for each accepted parcel and wraps modulo 2^AW.
- R9: While an instruction is waiting at the output and out_ready is low, the output does not change and in_ready stays low.
- R10: Flush discards a partly collected instruction, holds in_ready low for that cycle, and makes flush_addr the address of the next accepted parcel.
- R11: The misaligned flag is raised when the start address is odd while 16-bit support is on, or when it is not a multiple of 4 while 16-bit support is off. With 16-bit support off, a first parcel whose low bits are not 11 gives a 32-bit instruction that is flagged illegal, and a zero first parcel does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop the partial instruction and load flush_addr |
| flush_addr | input | AW | Address of the next parcel after a flush |
| in_valid | input | 1 | in_parcel is valid |
| in_parcel | input | 16 | Incoming instruction parcel |
| in_ready | output | 1 | The block takes a parcel in this cycle |
| out_valid | output | 1 | A complete instruction is present |
| out_ready | input | 1 | The consumer takes the instruction |
| out_insn | output | MAX_LEN | Assembled instruction, first parcel in the low bits |
| out_len | output | 8 | Instruction length in bits |
| out_addr | output | AW | Address of the first parcel |
| out_illegal | output | 1 | Illegal encoding |
| out_reserved | output | 1 | Reserved long-length encoding |
| out_misalign | output | 1 | Start address breaks the alignment rule |

## Verification
The bench runs every length code up to the maximum. It also sends a code one step beyond the maximum. A design that consumed the full decoded length would swallow the following 16-bit instruction, and one that did not truncate would report too long a length. The reserved code is sent both with ordinary payload and as all ones, so a design that tied the illegal flag to the reserved flag, or never set it, is caught. The bench also crosses the top of the address space, applies backpressure with a second parcel waiting, flushes in the middle of an instruction, and runs a variant without 16-bit support. These expose address counters that saturate, outputs that change or accept data while stalled, leftover partial parcels after a flush, and alignment checks that use the wrong mask.

// File: rtl/parcel_asm_pkg.sv
package parcel_asm_pkg;
   localparam int PARCEL_W   = 16;
   localparam int CNT_W      = 4;    // holds up to 11 parcels
   localparam int LEN_W      = 8;    // length in bits, up to 176
   localparam int MAX_LEN_HI = 176;

   typedef struct packed {
      logic [CNT_W-1:0] parcels;
      logic             reserved;
      logic             illegal;
   } len_code_t;
endpackage

// File: rtl/parcel_asm_len_decode.sv
module parcel_asm_len_decode
   import parcel_asm_pkg::*;
#(
   parameter int MAX_PARCELS = 6,
   parameter bit COMPRESSED  = 1'b1
) (
   input  logic [PARCEL_W-1:0] parcel,
   output len_code_t           code
);
   localparam logic [CNT_W-1:0] MAXP = CNT_W'(MAX_PARCELS);

   logic [CNT_W-1:0] short_n;
   logic             short_bad;

   generate
      if (COMPRESSED) begin : g_short16
         assign short_n   = CNT_W'(1);
         assign short_bad = (parcel == '0);
      end else begin : g_short32
         assign short_n   = CNT_W'(2);
         assign short_bad = 1'b1;
      end
   endgenerate

   logic [CNT_W-1:0] raw_n;
   logic             rsv;

   always_comb begin
      rsv = 1'b0;
      if (parcel[1:0] != 2'b11)
         raw_n = short_n;
      else if (parcel[4:2] != 3'b111)
         raw_n = CNT_W'(2);
      else if (!parcel[5])
         raw_n = CNT_W'(3);
      else if (!parcel[6])
         raw_n = CNT_W'(4);
      else if (parcel[14:12] != 3'b111)
         raw_n = CNT_W'(5) + {1'b0, parcel[14:12]};
      else begin
         raw_n = MAXP;
         rsv   = 1'b1;
      end
   end

   always_comb begin
      code.reserved = rsv;
      if (raw_n > MAXP) begin
         code.parcels = MAXP;
         code.illegal = 1'b1;
      end else begin
         code.parcels = raw_n;
         code.illegal = (parcel[1:0] != 2'b11) && short_bad;
      end
   end
endmodule

// File: rtl/parcel_asm_gather.sv
module parcel_asm_gather
   import parcel_asm_pkg::*;
#(
   parameter int MAX_PARCELS = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            clear,
   input  logic                            take,
   input  logic [PARCEL_W-1:0]             parcel,
   input  logic [CNT_W-1:0]                need_first,
   output logic                            first,
   output logic [CNT_W-1:0]                need_cur,
   output logic                            done,
   output logic [MAX_PARCELS*PARCEL_W-1:0] word_next
);
   localparam int W = MAX_PARCELS * PARCEL_W;

   logic [CNT_W-1:0] idx_q;
   logic [CNT_W-1:0] need_q;
   logic [W-1:0]     acc_q;

   assign first    = (idx_q == '0);
   assign need_cur = first ? need_first : need_q;
   assign done     = take && ((idx_q + CNT_W'(1)) == need_cur);

   generate
      for (genvar g = 0; g < MAX_PARCELS; g++) begin : g_slot
         assign word_next[g*PARCEL_W +: PARCEL_W] =
            (take && idx_q == CNT_W'(g)) ? parcel :
            first                        ? '0     :
                                           acc_q[g*PARCEL_W +: PARCEL_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         need_q <= '0;
         acc_q  <= '0;
      end else if (clear) begin
         idx_q <= '0;
      end else if (take) begin
         acc_q <= word_next;
         if (first) need_q <= need_first;
         if (done) idx_q <= '0;
         else      idx_q <= idx_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/parcel_asm_addr_ctr.sv
module parcel_asm_addr_ctr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_addr,
   input  logic          step,
   output logic [AW-1:0] pc
);
   always_ff @(posedge clk) begin
      if (!rst_n)    pc <= '0;
      else if (load) pc <= load_addr;
      else if (step) pc <= pc + AW'(2);
   end
endmodule

// File: rtl/parcel_asm.sv
module parcel_asm
   import parcel_asm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MAX_LEN    = 96,
   parameter bit COMPRESSED = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [AW-1:0]      flush_addr,
   input  logic               in_valid,
   input  logic [PARCEL_W-1:0] in_parcel,
   output logic               in_ready,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [MAX_LEN-1:0] out_insn,
   output logic [LEN_W-1:0]   out_len,
   output logic [AW-1:0]      out_addr,
   output logic               out_illegal,
   output logic               out_reserved,
   output logic               out_misalign
);
   localparam int MAXP = MAX_LEN / PARCEL_W;

   generate
      if (MAX_LEN % PARCEL_W != 0 || MAX_LEN < 32 || MAX_LEN > MAX_LEN_HI) begin : g_bad_len
         $error("parcel_asm: MAX_LEN must be a multiple of 16 in 32..176");
      end
      if (AW < 2) begin : g_bad_aw
         $error("parcel_asm: AW must be at least 2");
      end
   endgenerate

   logic                 take;
   logic                 first;
   logic                 done;
   logic [CNT_W-1:0]     need_cur;
   logic [MAX_LEN-1:0]   word_next;
   logic [AW-1:0]        pc;
   len_code_t            code;

   assign in_ready = !flush && (!out_valid || out_ready);
   assign take     = in_valid && in_ready;

   parcel_asm_len_decode #(.MAX_PARCELS(MAXP), .COMPRESSED(COMPRESSED)) u_dec (
      .parcel (in_parcel),
      .code   (code)
   );

   parcel_asm_gather #(.MAX_PARCELS(MAXP)) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (flush),
      .take       (take),
      .parcel     (in_parcel),
      .need_first (code.parcels),
      .first      (first),
      .need_cur   (need_cur),
      .done       (done),
      .word_next  (word_next)
   );

   parcel_asm_addr_ctr #(.AW(AW)) u_pc (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (flush),
      .load_addr (flush_addr),
      .step      (take),
      .pc        (pc)
   );

   // per-instruction attributes taken from the first parcel
   logic [AW-1:0] start_q;
   logic          rsv_q, bad_q;
   logic [AW-1:0] start_cur;
   logic          rsv_cur, bad_cur, mis_cur;

   assign start_cur = first ? pc : start_q;
   assign rsv_cur   = first ? code.reserved : rsv_q;
   assign bad_cur   = first ? code.illegal  : bad_q;

   generate
      if (COMPRESSED) begin : g_align16
         assign mis_cur = start_cur[0];
      end else begin : g_align32
         assign mis_cur = |start_cur[1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         rsv_q   <= 1'b0;
         bad_q   <= 1'b0;
      end else if (take && first) begin
         start_q <= pc;
         rsv_q   <= code.reserved;
         bad_q   <= code.illegal;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_insn     <= '0;
         out_len      <= '0;
         out_addr     <= '0;
         out_illegal  <= 1'b0;
         out_reserved <= 1'b0;
         out_misalign <= 1'b0;
      end else if (done) begin
         out_valid    <= 1'b1;
         out_insn     <= word_next;
         out_len      <= {need_cur, 4'b0000};
         out_addr     <= start_cur;
         out_reserved <= rsv_cur;
         out_illegal  <= bad_cur || (rsv_cur && (&word_next));
         out_misalign <= mis_cur;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/parcel_asm_checks.sv
module parcel_asm_checks
   import parcel_asm_pkg::*;
#(
   parameter int AW         = 32,
   parameter int MAX_LEN    = 96,
   parameter bit COMPRESSED = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flush,
   input logic [AW-1:0]      flush_addr,
   input logic               in_valid,
   input logic [PARCEL_W-1:0] in_parcel,
   input logic               in_ready,
   input logic               out_valid,
   input logic               out_ready,
   input logic [MAX_LEN-1:0] out_insn,
   input logic [LEN_W-1:0]   out_len,
   input logic [AW-1:0]      out_addr,
   input logic               out_illegal,
   input logic               out_reserved,
   input logic               out_misalign
);
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_insn)
                                  && $stable(out_addr) && $stable(out_len));

   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (int'(out_len) <= MAX_LEN) && (out_len[3:0] == 4'd0)
                    && (out_len != '0));

   assert_rsv_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_reserved |-> int'(out_len) == MAX_LEN);

   assert_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !in_ready);

   assert_min_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !COMPRESSED |-> out_len >= LEN_W'(32));

   assert_mis_R11: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_misalign |-> out_addr[1:0] != 2'b00);
endmodule

bind parcel_asm parcel_asm_checks #(
   .AW(AW), .MAX_LEN(MAX_LEN), .COMPRESSED(COMPRESSED)
) u_checks (.*);

// File: tb/parcel_asm_test.sv
module parcel_asm_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic rst_n = 1'b0;
   int   total = 0;
   int   bad   = 0;

   // main instance: 16-bit support, 96-bit maximum
   logic        flush = 0;
   logic [31:0] flush_addr = '0;
   logic        in_valid = 0;
   logic [15:0] in_parcel = '0;
   logic        in_ready;
   logic        out_valid;
   logic        out_ready = 1;
   logic [95:0] out_insn;
   logic [7:0]  out_len;
   logic [31:0] out_addr;
   logic        out_illegal, out_reserved, out_misalign;

   parcel_asm #(.AW(32), .MAX_LEN(96), .COMPRESSED(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
      .in_valid(in_valid), .in_parcel(in_parcel), .in_ready(in_ready),
      .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
      .out_len(out_len), .out_addr(out_addr), .out_illegal(out_illegal),
      .out_reserved(out_reserved), .out_misalign(out_misalign)
   );

   // second instance: no 16-bit support, 64-bit maximum
   logic        nc_flush = 0;
   logic [31:0] nc_flush_addr = '0;
   logic        nc_in_valid = 0;
   logic [15:0] nc_in_parcel = '0;
   logic        nc_in_ready;
   logic        nc_out_valid;
   logic [63:0] nc_out_insn;
   logic [7:0]  nc_out_len;
   logic [31:0] nc_out_addr;
   logic        nc_out_illegal, nc_out_reserved, nc_out_misalign;

   parcel_asm #(.AW(32), .MAX_LEN(64), .COMPRESSED(1'b0)) uut_nc (
      .clk(clk), .rst_n(rst_n), .flush(nc_flush), .flush_addr(nc_flush_addr),
      .in_valid(nc_in_valid), .in_parcel(nc_in_parcel), .in_ready(nc_in_ready),
      .out_valid(nc_out_valid), .out_ready(1'b1), .out_insn(nc_out_insn),
      .out_len(nc_out_len), .out_addr(nc_out_addr), .out_illegal(nc_out_illegal),
      .out_reserved(nc_out_reserved), .out_misalign(nc_out_misalign)
   );

   // output monitor for the main instance
   logic [95:0] c_insn [64];
   logic [7:0]  c_len  [64];
   logic [31:0] c_addr [64];
   logic        c_ill  [64];
   logic        c_rsv  [64];
   logic        c_mis  [64];
   int          c_n = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && c_n < 64) begin
         c_insn[c_n] = out_insn;
         c_len[c_n]  = out_len;
         c_addr[c_n] = out_addr;
         c_ill[c_n]  = out_illegal;
         c_rsv[c_n]  = out_reserved;
         c_mis[c_n]  = out_misalign;
         c_n++;
      end
   end

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] p);
      @(posedge clk); #1;
      in_valid  = 1'b1;
      in_parcel = p;
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
      in_valid = 1'b0;
   endtask

   task automatic send_nc(input logic [15:0] p);
      @(posedge clk); #1;
      nc_in_valid  = 1'b1;
      nc_in_parcel = p;
      do @(negedge clk); while (!nc_in_ready);
      @(posedge clk); #1;
      nc_in_valid = 1'b0;
   endtask

   task automatic do_flush(input logic [31:0] a);
      @(posedge clk); #1;
      flush = 1'b1; flush_addr = a;
      @(negedge clk);
      check("R10 in_ready during flush", 128'(in_ready), 128'(0));
      @(posedge clk); #1;
      flush = 1'b0;
      c_n = 0;
   endtask

   task automatic settle();
      repeat (2) @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input int i, input logic [95:0] insn, input int len,
                             input logic [31:0] addr, input logic ill, input logic rsv,
                             input logic mis, input string tag);
      check({tag, " count"}, 128'(c_n > i), 128'(1));
      if (c_n > i) begin
         check({tag, " insn"},     128'(c_insn[i]), 128'(insn));
         check({tag, " len"},      128'(c_len[i]),  128'(len));
         check({tag, " addr"},     128'(c_addr[i]), 128'(addr));
         check({tag, " illegal"},  128'(c_ill[i]),  128'(ill));
         check({tag, " reserved"}, 128'(c_rsv[i]),  128'(rsv));
         check({tag, " misalign"}, 128'(c_mis[i]),  128'(mis));
      end
   endtask

   task automatic t_reset();
      check("R9 reset out_valid", 128'(out_valid), 128'(0));
      check("R9 reset in_ready",  128'(in_ready),  128'(1));
      check("R11 reset nc out_valid", 128'(nc_out_valid), 128'(0));
   endtask

   task automatic t_short();
      do_flush(32'h100);
      send(16'h1234);
      send(16'h0001);
      send(16'hFFFE);
      settle();
      expect_out(0, 96'h1234, 16, 32'h100, 0, 0, 0, "R1 a");
      expect_out(1, 96'h0001, 16, 32'h102, 0, 0, 0, "R1 b");
      expect_out(2, 96'hFFFE, 16, 32'h104, 0, 0, 0, "R1 c");
   endtask

   task automatic t_mid();
      do_flush(32'h200);
      send(16'hA0B3); send(16'h5566);
      send(16'hC01F); send(16'h1111); send(16'h2222);
      send(16'h123F); send(16'h3333); send(16'h4444); send(16'h5555);
      settle();
      expect_out(0, 96'h5566_A0B3, 32, 32'h200, 0, 0, 0, "R2");
      expect_out(1, 96'h2222_1111_C01F, 48, 32'h204, 0, 0, 0, "R3 48");
      expect_out(2, 96'h5555_4444_3333_123F, 64, 32'h20A, 0, 0, 0, "R3 64");
   endtask

   task automatic t_long();
      do_flush(32'h300);
      send(16'h007F); send(16'h1111); send(16'h2222); send(16'h3333); send(16'h4444);
      send(16'h107F); send(16'hA1A1); send(16'hB2B2); send(16'hC3C3); send(16'hD4D4);
      send(16'hE5E5);
      settle();
      expect_out(0, 96'h4444_3333_2222_1111_007F, 80, 32'h300, 0, 0, 0, "R4 80");
      expect_out(1, 96'hE5E5_D4D4_C3C3_B2B2_A1A1_107F, 96, 32'h30A, 0, 0, 0, "R4 96");
   endtask

   task automatic t_over();
      do_flush(32'h400);
      send(16'h207F); send(16'h0001); send(16'h0002); send(16'h0003);
      send(16'h0004); send(16'h0005);
      send(16'h0002);
      settle();
      expect_out(0, 96'h0005_0004_0003_0002_0001_207F, 96, 32'h400, 1, 0, 0, "R7 truncated");
      expect_out(1, 96'h0002, 16, 32'h40C, 0, 0, 0, "R7 next");
   endtask

   task automatic t_reserved();
      do_flush(32'h500);
      send(16'h707F);
      for (int k = 0; k < 5; k++) send(16'hAAAA);
      for (int k = 0; k < 6; k++) send(16'hFFFF);
      settle();
      expect_out(0, 96'hAAAA_AAAA_AAAA_AAAA_AAAA_707F, 96, 32'h500, 0, 1, 0, "R5 payload");
      expect_out(1, {96{1'b1}}, 96, 32'h50C, 1, 1, 0, "R5 all ones");
   endtask

   task automatic t_zero();
      do_flush(32'h600);
      send(16'h0000);
      send(16'h0004);
      settle();
      expect_out(0, 96'h0, 16, 32'h600, 1, 0, 0, "R6 zero");
      expect_out(1, 96'h4, 16, 32'h602, 0, 0, 0, "R6 after");
   endtask

   task automatic t_wrap();
      do_flush(32'hFFFF_FFFE);
      send(16'h00B3); send(16'h1234);
      send(16'h0005);
      settle();
      expect_out(0, 96'h1234_00B3, 32, 32'hFFFF_FFFE, 0, 0, 0, "R8 top");
      expect_out(1, 96'h0005, 16, 32'h0000_0002, 0, 0, 0, "R8 wrapped");
   endtask

   task automatic t_backpressure();
      do_flush(32'h700);
      out_ready = 1'b0;
      send(16'h1230);
      @(posedge clk); #1;
      in_valid = 1'b1; in_parcel = 16'h4560;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R9 stalled in_ready", 128'(in_ready), 128'(0));
         check("R9 held valid", 128'(out_valid), 128'(1));
         check("R9 held insn", 128'(out_insn), 128'(96'h1230));
      end
      @(posedge clk); #1;
      out_ready = 1'b1;
      @(negedge clk);
      check("R9 released in_ready", 128'(in_ready), 128'(1));
      @(posedge clk); #1;
      in_valid = 1'b0;
      settle();
      check("R9 delivered count", 128'(c_n), 128'(2));
      expect_out(0, 96'h1230, 16, 32'h700, 0, 0, 0, "R9 first");
      expect_out(1, 96'h4560, 16, 32'h702, 0, 0, 0, "R9 second");
   endtask

   task automatic t_flush_mid();
      do_flush(32'h800);
      send(16'h00B3);
      do_flush(32'h2000);
      send(16'h0004);
      settle();
      check("R10 one result", 128'(c_n), 128'(1));
      expect_out(0, 96'h0004, 16, 32'h2000, 0, 0, 0, "R10 new start");
   endtask

   task automatic t_misalign();
      do_flush(32'h901);
      send(16'h0004);
      settle();
      expect_out(0, 96'h0004, 16, 32'h901, 0, 0, 1, "R11 odd start");
   endtask

   task automatic nc_flush_to(input logic [31:0] a);
      @(posedge clk); #1;
      nc_flush = 1'b1; nc_flush_addr = a;
      @(posedge clk); #1;
      nc_flush = 1'b0;
   endtask

   task automatic t_nc();
      nc_flush_to(32'h10);
      send_nc(16'h00B3); send_nc(16'h0001);
      check("R11 nc valid a",  128'(nc_out_valid), 128'(1));
      check("R11 nc len a",    128'(nc_out_len), 128'(32));
      check("R11 nc insn a",   128'(nc_out_insn), 128'(64'h0001_00B3));
      check("R11 nc mis a",    128'(nc_out_misalign), 128'(0));
      check("R11 nc ill a",    128'(nc_out_illegal), 128'(0));
      nc_flush_to(32'h12);
      send_nc(16'h00B3); send_nc(16'h0001);
      check("R11 nc mis b",    128'(nc_out_misalign), 128'(1));
      check("R11 nc addr b",   128'(nc_out_addr), 128'(32'h12));
      nc_flush_to(32'h20);
      send_nc(16'h0000); send_nc(16'h0000);
      check("R11 nc zero len", 128'(nc_out_len), 128'(32));
      check("R11 nc zero ill", 128'(nc_out_illegal), 128'(1));
      send_nc(16'h0001); send_nc(16'h7777);
      check("R11 nc short len", 128'(nc_out_len), 128'(32));
      check("R11 nc short ill", 128'(nc_out_illegal), 128'(1));
      check("R11 nc short insn", 128'(nc_out_insn), 128'(64'h7777_0001));
      check("R11 nc short addr", 128'(nc_out_addr), 128'(32'h24));
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_short();
      t_mid();
      t_long();
      t_over();
      t_reserved();
      t_zero();
      t_wrap();
      t_backpressure();
      t_flush_mid();
      t_misalign();
      t_nc();
      finish_run();
   end
endmodule